// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block holds a 64-bit interrupt command, split into two memory-mapped 32-bit words, and sends one interrupt message to other processors for each command. Software first writes the high word, which carries the explicit target processor number. It then writes the low word, which carries the vector, the delivery mode, the trigger type, the level flag and a two-bit destination shorthand. The write to the low word, and only that write, starts a send. The unit resolves the shorthand into a bitmask over `NUM_CPU` processors, latches the message and offers it on a valid/ready output port.

A delivery-status bit in the low word reads 1 from the launching write until the port accepts the message. Software polls this bit before it issues the next command. A low-word write made while a message is still waiting is dropped and raises a send-error flag. A write that lands in the same cycle as the acceptance is taken as the next command, so a start-up sequence of INIT assert, INIT de-assert and two STARTUP messages can run back to back.

Top module: `ipi_cmd_unit`

## Requirements
- R1: While reset is asserted and after it is released, `msg_valid` is 0 and both command words read 0.
- R2: A write to byte offset 0x310 stores bits 31:24 as the target processor number. Reading that offset returns the number in bits 31:24 and zeros elsewhere. That write never starts a message.
- R3: A write to offset 0x300 while no message is pending raises `msg_valid` at the next clock edge. The port then carries vector = bits 7:0, mode = bits 10:8 (000 fixed, 101 INIT, 110 STARTUP), trigger = bit 15 (1 = level) and level = bit 14 (1 assert, 0 de-assert).
- R4: While `msg_valid` is 1 and `msg_ready` is 0, the message and its destination mask stay unchanged.
- R5: Bit 12 of the low word reads 1 from the edge that launches a message through the edge where `msg_ready` is seen with `msg_valid`. It reads 0 after that edge, and `msg_valid` follows the same timing.
- R6: Shorthand 00 (low-word bits 19:18) sends to the explicit target only. Its mask bit is one-hot at the target number, or all-zero if the number is `NUM_CPU` or above.
- R7: Shorthand 01 sets only the `self_id` bit. Shorthand 10 sets every bit. Shorthand 11 sets every bit except `self_id`. `self_id` is sampled at the launching write.
- R8: A low-word write while a message is pending and `msg_ready` is 0 is dropped. The pending message is unchanged, and bit 20 of the low word (send error) reads 1 afterwards.
- R9: A low-word write in the cycle where the pending message is accepted launches the new message at once, so `msg_valid` stays 1. Any accepted launch clears the send-error bit.
- R10: Low-word bits 17:16 (remote-read status) always read 00. Bits 11, 13 and 31:21 of the low word read 0, and any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | ID_W | Number of the processor that owns this unit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset (writes and reads) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken by the interconnect |
| msg_vector | output | 8 | Interrupt vector or start page |
| msg_mode | output | 3 | Delivery mode |
| msg_trig_level | output | 1 | 1 = level-triggered |
| msg_level_assert | output | 1 | 1 = assert, 0 = de-assert |
| msg_dest | output | NUM_CPU | Destination processor mask |

## Verification
Every stored result is due one clock edge after the stimulus that causes it. The message fields, `msg_valid`, the busy bit, the error bit and the stored target number all change at the edge that samples the write or the handshake. `reg_rdata` reflects that state in the same cycle the address is driven. The bench drives each input on a falling edge and compares every output 1 ns later, against a model that it advances only after the following rising edge. Each comparison therefore sees exactly one edge's worth of change. Directed sequences cover the held message, the dropped write, the accept-and-launch cycle and the start-up sequence. Seeded random traffic then mixes both words, other offsets and a toggling `msg_ready`.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef struct packed {
    shorthand_e  sh;
    logic        trig;
    logic        level;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } cmd_t;

  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int BUSY_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int TRIG_BIT = 15;
  localparam int RRS_LSB  = 16;
  localparam int SH_LSB   = 18;
  localparam int ERR_BIT  = 20;
  localparam int DEST_LSB = 24;

  localparam logic [1:0] RRS_INVALID = 2'b00;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          ID_W   = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'(12'h300),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'(12'h310)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  cmd_t              cmd_q,
  input  logic              busy,
  input  logic              err,
  output logic              lo_wr,
  output logic [ID_W-1:0]   dest_id,
  output cmd_t              wcmd,
  output logic [31:0]       rdata
);
  logic            hi_wr;
  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] id_d;
  logic            unused_wbits;

  assign lo_wr = wr && (addr == LO_OFS);
  assign hi_wr = wr && (addr == HI_OFS);
  assign unused_wbits = ^wdata;

  always_comb begin
    wcmd.vector = wdata[VEC_LSB +: 8];
    wcmd.mode   = wdata[MODE_LSB +: 3];
    wcmd.level  = wdata[LVL_BIT];
    wcmd.trig   = wdata[TRIG_BIT];
    wcmd.sh     = shorthand_e'(wdata[SH_LSB +: 2]);
  end

  always_comb begin
    id_d = id_q;
    if (hi_wr) id_d = wdata[DEST_LSB +: ID_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= id_d;
  end

  assign dest_id = id_q;

  always_comb begin
    rdata = '0;
    if (addr == LO_OFS) begin
      rdata[VEC_LSB +: 8]  = cmd_q.vector;
      rdata[MODE_LSB +: 3] = cmd_q.mode;
      rdata[BUSY_BIT]      = busy;
      rdata[LVL_BIT]       = cmd_q.level;
      rdata[TRIG_BIT]      = cmd_q.trig;
      rdata[RRS_LSB +: 2]  = RRS_INVALID;
      rdata[SH_LSB +: 2]   = cmd_q.sh;
      rdata[ERR_BIT]       = err;
    end else if (addr == HI_OFS) begin
      rdata[DEST_LSB +: ID_W] = id_q;
    end
  end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ID_W    = 8
) (
  input  shorthand_e         sh,
  input  logic [ID_W-1:0]    dest_id,
  input  logic [ID_W-1:0]    self_id,
  output logic [NUM_CPU-1:0] mask
);
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    localparam logic [ID_W-1:0] IDX = ID_W'(i);
    logic hit_dest;
    logic hit_self;
    assign hit_dest = (dest_id == IDX);
    assign hit_self = (self_id == IDX);
    always_comb begin
      unique case (sh)
        SH_NONE:   mask[i] = hit_dest;
        SH_SELF:   mask[i] = hit_self;
        SH_ALL:    mask[i] = 1'b1;
        default:   mask[i] = !hit_self;
      endcase
    end
  end
endmodule

// File: rtl/ipi_send_engine.sv
module ipi_send_engine
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_wr,
  input  cmd_t               wcmd,
  input  logic [NUM_CPU-1:0] wmask,
  input  logic               msg_ready,
  output logic               busy,
  output logic               err,
  output cmd_t               cmd_q,
  output logic [NUM_CPU-1:0] dest_q
);
  logic               busy_q, busy_d;
  logic               err_q, err_d;
  cmd_t               cmd_d;
  logic [NUM_CPU-1:0] dest_d;
  logic               accept;
  logic               launch;

  assign accept = busy_q && msg_ready;
  assign launch = lo_wr && (!busy_q || msg_ready);

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    cmd_d  = cmd_q;
    dest_d = dest_q;
    if (launch) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
      cmd_d  = wcmd;
      dest_d = wmask;
    end else begin
      if (accept) busy_d = 1'b0;
      if (lo_wr)  err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cmd_q  <= '0;
      dest_q <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      cmd_q  <= cmd_d;
      dest_q <= dest_d;
    end
  end

  assign busy = busy_q;
  assign err  = err_q;
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ID_W    = 8,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'(12'h300),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'(12'h310)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    self_id,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [2:0]         msg_mode,
  output logic               msg_trig_level,
  output logic               msg_level_assert,
  output logic [NUM_CPU-1:0] msg_dest
);
  logic               rst_sync_n;
  logic               lo_wr;
  logic [ID_W-1:0]    dest_id;
  cmd_t               wcmd;
  cmd_t               cmd_q;
  logic [NUM_CPU-1:0] wmask;
  logic               busy;
  logic               send_err;

  ipi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipi_regs #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cmd_q   (cmd_q),
    .busy    (busy),
    .err     (send_err),
    .lo_wr   (lo_wr),
    .dest_id (dest_id),
    .wcmd    (wcmd),
    .rdata   (reg_rdata)
  );

  ipi_dest_resolve #(
    .NUM_CPU (NUM_CPU),
    .ID_W    (ID_W)
  ) u_dest (
    .sh      (wcmd.sh),
    .dest_id (dest_id),
    .self_id (self_id),
    .mask    (wmask)
  );

  ipi_send_engine #(.NUM_CPU(NUM_CPU)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lo_wr     (lo_wr),
    .wcmd      (wcmd),
    .wmask     (wmask),
    .msg_ready (msg_ready),
    .busy      (busy),
    .err       (send_err),
    .cmd_q     (cmd_q),
    .dest_q    (msg_dest)
  );

  assign msg_valid        = busy;
  assign msg_vector       = cmd_q.vector;
  assign msg_mode         = cmd_q.mode;
  assign msg_trig_level   = cmd_q.trig;
  assign msg_level_assert = cmd_q.level;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
  parameter int NUM_CPU = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lo_wr,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [2:0]         msg_mode,
  input logic [NUM_CPU-1:0] msg_dest,
  input logic               send_err
);
  // R3: an idle low-word write launches a message
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && !msg_valid |=> msg_valid);

  // R4: a waiting message holds still
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest)
                                && $stable(msg_vector) && $stable(msg_mode));

  // R5: acceptance without a new write ends the busy period
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && !lo_wr |=> !msg_valid);

  // R8: a dropped write flags an error
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && msg_valid && !msg_ready |=> send_err && msg_valid);

  // R9: an accepted launch keeps valid and clears the error
  a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && (!msg_valid || msg_ready) |=> msg_valid && !send_err);
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lo_wr      (lo_wr),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_mode   (msg_mode),
  .msg_dest   (msg_dest),
  .send_err   (send_err)
);

// File: tb/sim_ipi_cmd_unit.sv
module sim_ipi_cmd_unit;
  localparam int NCPU = 8;
  localparam int IDW  = 8;
  localparam int AW   = 12;
  localparam logic [AW-1:0] LO = 12'h300;
  localparam logic [AW-1:0] HI = 12'h310;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [IDW-1:0]  self_id;
  logic            reg_wr;
  logic [AW-1:0]   reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            msg_valid;
  logic            msg_ready;
  logic [7:0]      msg_vector;
  logic [2:0]      msg_mode;
  logic            msg_trig_level;
  logic            msg_level_assert;
  logic [NCPU-1:0] msg_dest;

  always #2 clk = ~clk;

  ipi_cmd_unit #(.NUM_CPU(NCPU), .ID_W(IDW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_trig_level(msg_trig_level),
    .msg_level_assert(msg_level_assert), .msg_dest(msg_dest)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  logic            m_busy, m_err, m_trig, m_lvl;
  logic [7:0]      m_vec, m_hi;
  logic [2:0]      m_mode;
  logic [1:0]      m_sh;
  logic [NCPU-1:0] m_dest;

  function automatic logic [NCPU-1:0] exp_mask(logic [1:0] sh, logic [7:0] id, logic [7:0] me);
    logic [NCPU-1:0] m;
    m = '0;
    case (sh)
      2'b00: if (id < NCPU) m[id[2:0]] = 1'b1;
      2'b01: if (me < NCPU) m[me[2:0]] = 1'b1;
      2'b10: m = '1;
      default: begin m = '1; if (me < NCPU) m[me[2:0]] = 1'b0; end
    endcase
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    if (a == LO) return {11'b0, m_err, m_sh, 2'b00, m_trig, m_lvl, 1'b0, m_busy, 1'b0, m_mode, m_vec};
    if (a == HI) return {m_hi, 24'b0};
    return 32'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3/R5 msg_valid", 32'(msg_valid), 32'(m_busy));
    if (m_busy) begin
      chk("R3 vector", 32'(msg_vector), 32'(m_vec));
      chk("R3 mode", 32'(msg_mode), 32'(m_mode));
      chk("R3 trigger", 32'(msg_trig_level), 32'(m_trig));
      chk("R3 level", 32'(msg_level_assert), 32'(m_lvl));
      chk(m_sh == 2'b00 ? "R6 dest" : "R7 dest", 32'(msg_dest), 32'(m_dest));
    end
    if (reg_addr == LO)      chk("R5/R8/R10 low word", reg_rdata, exp_rd(reg_addr));
    else if (reg_addr == HI) chk("R2 high word", reg_rdata, exp_rd(reg_addr));
    else                     chk("R10 other offset", reg_rdata, 32'b0);
  endtask

  task automatic step(logic wr, logic [AW-1:0] a, logic [31:0] d, logic rdy);
    logic lo_w, hi_w;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; msg_ready = rdy;
    #1;
    check_all();
    @(posedge clk);
    lo_w = wr && (a == LO);
    hi_w = wr && (a == HI);
    if (lo_w && (!m_busy || rdy)) begin
      m_busy = 1'b1; m_err = 1'b0;
      m_vec = d[7:0]; m_mode = d[10:8]; m_lvl = d[14]; m_trig = d[15]; m_sh = d[19:18];
      m_dest = exp_mask(d[19:18], m_hi, self_id);
    end else begin
      if (m_busy && rdy) m_busy = 1'b0;
      if (lo_w) m_err = 1'b1;
    end
    if (hi_w) m_hi = d[31:24];
  endtask

  function automatic logic [31:0] lo_word(logic [1:0] sh, logic trig, logic lvl, logic [2:0] mode, logic [7:0] vec);
    return {12'b0, sh, 2'b00, trig, lvl, 3'b000, mode, vec};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; self_id = 8'd3; reg_wr = 1'b0; reg_addr = LO; reg_wdata = '0; msg_ready = 1'b0;
    m_busy = 0; m_err = 0; m_trig = 0; m_lvl = 0; m_vec = 0; m_hi = 0; m_mode = 0; m_sh = 0; m_dest = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid in reset", 32'(msg_valid), 32'd0);
    chk("R1 low word in reset", reg_rdata, 32'd0);
    reg_addr = HI; #1;
    chk("R1 high word in reset", reg_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, LO, 32'h0, 1'b0);
    chk("R1 valid after release", 32'(msg_valid), 32'd0);

    // R2: high word store, no launch
    step(1'b1, HI, 32'hAB12_3456, 1'b0);
    step(1'b0, HI, 32'h0, 1'b0);
    chk("R2 high read", reg_rdata, 32'hAB00_0000);
    chk("R2 no launch", 32'(msg_valid), 32'd0);

    // R6 explicit target 2, held for R4, dropped write for R8
    step(1'b1, HI, 32'h0200_0000, 1'b0);
    step(1'b1, LO, lo_word(2'b00, 1'b0, 1'b0, 3'b000, 8'h31), 1'b0);
    step(1'b0, LO, 32'h0, 1'b0);
    chk("R6 one-hot target", 32'(msg_dest), 32'h04);
    step(1'b1, LO, lo_word(2'b10, 1'b1, 1'b1, 3'b101, 8'h77), 1'b0);
    step(1'b0, LO, 32'h0, 1'b0);
    chk("R4 hold vector", 32'(msg_vector), 32'h31);
    chk("R8 err bit", 32'(reg_rdata[20]), 32'd1);
    chk("R5 busy bit", 32'(reg_rdata[12]), 32'd1);
    step(1'b0, LO, 32'h0, 1'b1);
    step(1'b0, LO, 32'h0, 1'b0);
    chk("R5 busy cleared", 32'(reg_rdata[12]), 32'd0);

    // R6 out-of-range target
    step(1'b1, HI, 32'h2000_0000, 1'b0);
    step(1'b1, LO, lo_word(2'b00, 1'b0, 1'b0, 3'b000, 8'h40), 1'b1);
    step(1'b0, LO, 32'h0, 1'b1);
    chk("R6 out of range mask", 32'(msg_dest), 32'h00);
    step(1'b0, LO, 32'h0, 1'b0);

    // R7 shorthands with self_id 3
    for (int s = 1; s < 4; s++) begin
      step(1'b1, LO, lo_word(2'(s), 1'b0, 1'b0, 3'b000, 8'h50), 1'b0);
      step(1'b0, LO, 32'h0, 1'b1);
      chk("R7 shorthand mask", 32'(msg_dest), s == 1 ? 32'h08 : s == 2 ? 32'hFF : 32'hF7);
      step(1'b0, LO, 32'h0, 1'b0);
    end

    // R9: start-up sequence back to back with ready held high
    step(1'b1, HI, 32'h0500_0000, 1'b1);
    step(1'b1, LO, lo_word(2'b00, 1'b1, 1'b1, 3'b101, 8'h00), 1'b1);
    step(1'b1, LO, lo_word(2'b10, 1'b1, 1'b0, 3'b101, 8'h00), 1'b1);
    chk("R9 INIT assert out", 32'(msg_level_assert), 32'd1);
    step(1'b1, LO, lo_word(2'b00, 1'b0, 1'b0, 3'b110, 8'h09), 1'b1);
    chk("R9 INIT deassert out", 32'(msg_level_assert), 32'd0);
    step(1'b1, LO, lo_word(2'b00, 1'b0, 1'b0, 3'b110, 8'h09), 1'b1);
    chk("R9 STARTUP chained", 32'(msg_mode), 32'd6);
    step(1'b0, LO, 32'h0, 1'b1);
    chk("R9 second STARTUP", 32'(msg_dest), 32'h20);
    chk("R9 no error", 32'(reg_rdata[20]), 32'd0);
    step(1'b0, LO, 32'h0, 1'b0);
    step(1'b0, 12'h304, 32'h0, 1'b0);
    chk("R10 neighbour offset", reg_rdata, 32'h0);

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [AW-1:0] a;
      r = int'($urandom % 8);
      a = (r < 3) ? LO : (r == 3) ? HI : (r == 4) ? AW'($urandom) : ($urandom % 2 ? LO : HI);
      if (i == 2000) self_id = 8'd6;
      step(r < 5, a, $urandom, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule